// File: doc/BRIEF.md
# Oscillator Event Interrupt Controller

This block gathers clock-system events into three word-addressed registers and one interrupt line. Four oscillator ready indications arrive as levels: internal low-speed, external low-speed, internal high-speed and external high-speed. Two failure detections on the external oscillators arrive as single-cycle or held pulses. Software arms the ready events through an enable register. Hardware latches events into a flag register. Software acknowledges a flag by writing a one to the matching bit of a separate clear register.

A ready flag latches only on the rising edge of its ready level, and only while its enable bit is set. A ready level that stays high therefore cannot set a flag again after software has cleared it. The internal high-speed ready flag also requires a qualifier input. This input is high only when software, not a peripheral request, switched that oscillator on. The failure flags ignore the enable register. The interrupt request is the OR of every flag. The flag register is always visible on an output port.

Top module: `oscevt_irq_ctrl`

## Requirements
- R1: After reset the flag output and the interrupt are 0, and every enable bit is 0.
- R2: When a ready level rises while its enable bit is 1, the flag at the same position is 1 on the cycle after that edge. The positions are: internal low-speed 0, external low-speed 1, internal high-speed 3, external high-speed 4. The enable register is at word address 0.
- R3: A ready edge that occurs while its enable bit is 0 sets no flag. Setting the enable bit later, while the level stays high, sets no flag either.
- R4: A flag that software has cleared stays 0 while its ready level remains high. Only a new rising edge can set it again.
- R5: The internal high-speed flag (bit 3) sets only when the qualifier `hsi_sw_on_i` is 1 in the cycle of the edge.
- R6: In every cycle that `hse_fail_i` is 1, flag bit 8 is 1 on the next cycle. In every cycle that `lse_fail_i` is 1, flag bit 9 is 1 on the next cycle. The enable register has no effect on either flag.
- R7: Writing to word address 2 clears, on the next cycle, every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: When a set event and a clear write hit the same flag in the same cycle, the flag is 1 afterwards.
- R9: `irq_o` is 1 exactly when at least one flag bit is 1, in the same cycle.
- R10: Writes to word addresses 1 and 3 change nothing. Flag bits other than 0, 1, 3, 4, 8 and 9 always read 0. Enable bits other than 0, 1, 3 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W (2) | Word address: 0 enable, 2 clear |
| wr_data_i | input | DATA_W (32) | Write data |
| lsi_rdy_i | input | 1 | Internal low-speed oscillator ready level |
| lse_rdy_i | input | 1 | External low-speed oscillator ready level |
| hsi_rdy_i | input | 1 | Internal high-speed oscillator ready level |
| hse_rdy_i | input | 1 | External high-speed oscillator ready level |
| hsi_sw_on_i | input | 1 | 1 when software started the internal high-speed oscillator |
| hse_fail_i | input | 1 | External high-speed failure detected |
| lse_fail_i | input | 1 | External low-speed failure detected |
| evt_flags_o | output | DATA_W (32) | Flag register readback |
| irq_o | output | 1 | Interrupt request |

## Verification
A hardware set and a software clear can fall on the same flag in the same cycle. The bench provokes this in two ways. It raises a ready level, or pulses a failure input, in exactly the cycle in which the clear write for that bit is on the bus. Many random cycles then mix ready toggles, failure pulses and clear writes to any address. A behavioural model applies the rule that the set wins. Every cycle it compares its flag word and interrupt with the design. Any difference is judged against the requirement of the current phase.

// File: rtl/oscevt_pkg.sv
package oscevt_pkg;

  // Bit positions shared by the enable, flag and clear registers
  localparam int unsigned POS_LSI_RDY  = 0;
  localparam int unsigned POS_LSE_RDY  = 1;
  localparam int unsigned POS_HSI_RDY  = 3;
  localparam int unsigned POS_HSE_RDY  = 4;
  localparam int unsigned POS_HSE_FAIL = 8;
  localparam int unsigned POS_LSE_FAIL = 9;
  localparam int unsigned N_RDY        = 4;
  localparam int unsigned MIN_DATA_W   = 10;

  // Word addresses of the register slots
  typedef enum logic [1:0] {
    SLOT_ENA  = 2'd0,
    SLOT_FLAG = 2'd1,
    SLOT_CLR  = 2'd2,
    SLOT_RSVD = 2'd3
  } slot_e;

  function automatic int unsigned rdy_pos(input int unsigned idx);
    case (idx)
      0:       return POS_LSI_RDY;
      1:       return POS_LSE_RDY;
      2:       return POS_HSI_RDY;
      default: return POS_HSE_RDY;
    endcase
  endfunction

  function automatic logic [31:0] rdy_mask();
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < N_RDY; i++) m[rdy_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] fail_mask();
    logic [31:0] m;
    m = '0;
    m[POS_HSE_FAIL] = 1'b1;
    m[POS_LSE_FAIL] = 1'b1;
    return m;
  endfunction

  // The set term is ORed after the clear term, so a set always wins
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] set,
                                            input logic [31:0] clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/oscevt_rise.sv
module oscevt_rise #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/oscevt_ena.sv
module oscevt_ena #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] en_o
);
  import oscevt_pkg::*;

  localparam logic [DATA_W-1:0] ENA_MASK = DATA_W'(rdy_mask());

  logic              wr_hit;
  logic [DATA_W-1:0] en_q;

  assign wr_hit = wr_en_i && (wr_addr_i == ADDR_W'(SLOT_ENA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= wr_data_i & ENA_MASK;
  end

  assign en_o = en_q;

  // R10
  ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_q));

endmodule

// File: rtl/oscevt_flags.sv
module oscevt_flags #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] flag_o
);
  import oscevt_pkg::*;

  logic [DATA_W-1:0] flag_q;
  logic [31:0]       nxt_wide;

  assign nxt_wide = flag_next(32'(flag_q), 32'(set_i), 32'(clr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= nxt_wide[DATA_W-1:0];
  end

  assign flag_o = flag_q;

  // R7
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R4
  rise_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/oscevt_irq_ctrl.sv
module oscevt_irq_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lsi_rdy_i,
  input  logic              lse_rdy_i,
  input  logic              hsi_rdy_i,
  input  logic              hse_rdy_i,
  input  logic              hsi_sw_on_i,
  input  logic              hse_fail_i,
  input  logic              lse_fail_i,
  output logic [DATA_W-1:0] evt_flags_o,
  output logic              irq_o
);
  import oscevt_pkg::*;

  initial begin
    if (DATA_W < MIN_DATA_W) $error("DATA_W too small for the flag layout");
  end

  logic [DATA_W-1:0] rdy_vec;
  logic [DATA_W-1:0] rise_vec;
  logic [DATA_W-1:0] en_vec;
  logic [DATA_W-1:0] qual_vec;
  logic [DATA_W-1:0] fail_vec;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic              clr_hit;

  // Place the ready levels and the failure pulses at their bit positions
  always_comb begin
    rdy_vec                = '0;
    rdy_vec[POS_LSI_RDY]   = lsi_rdy_i;
    rdy_vec[POS_LSE_RDY]   = lse_rdy_i;
    rdy_vec[POS_HSI_RDY]   = hsi_rdy_i;
    rdy_vec[POS_HSE_RDY]   = hse_rdy_i;
    qual_vec               = '1;
    qual_vec[POS_HSI_RDY]  = hsi_sw_on_i;
    fail_vec               = '0;
    fail_vec[POS_HSE_FAIL] = hse_fail_i;
    fail_vec[POS_LSE_FAIL] = lse_fail_i;
  end

  oscevt_rise #(.W(DATA_W)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (rdy_vec),
    .rise_o (rise_vec)
  );

  oscevt_ena #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ena (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_vec)
  );

  assign set_vec = (rise_vec & en_vec & qual_vec) | fail_vec;
  assign clr_hit = wr_en_i && (wr_addr_i == ADDR_W'(SLOT_CLR));
  assign clr_vec = clr_hit ? wr_data_i : '0;

  oscevt_flags #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (evt_flags_o)
  );

  assign irq_o = |evt_flags_o;

  // R3
  for (genvar g = 0; g < N_RDY; g++) begin : g_rdy_chk
    localparam int unsigned B = rdy_pos(g);
    rdy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_flags_o[B]) |-> $past(en_vec[B] && rdy_vec[B]));
  end

  // R5
  hsi_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags_o[POS_HSI_RDY]) |-> $past(hsi_sw_on_i));

  // R6
  hse_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hse_fail_i |=> evt_flags_o[POS_HSE_FAIL]);

  // R6
  lse_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lse_fail_i |=> evt_flags_o[POS_LSE_FAIL]);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(set_vec != '0));

endmodule

// File: tb/oscevt_irq_ctrl_bench.sv
module oscevt_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        lsi = 1'b0, lse = 1'b0, hsi = 1'b0, hse = 1'b0;
  logic        sw_on = 1'b0, hfail = 1'b0, lfail = 1'b0;
  logic [31:0] flags;
  logic        irq;

  always #2.5 clk = ~clk;

  oscevt_irq_ctrl u_oscevt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lsi_rdy_i(lsi), .lse_rdy_i(lse), .hsi_rdy_i(hsi),
    .hse_rdy_i(hse), .hsi_sw_on_i(sw_on), .hse_fail_i(hfail),
    .lse_fail_i(lfail), .evt_flags_o(flags), .irq_o(irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string req = "R1";

  // Behavioural reference state
  logic [31:0] m_en = '0, m_flag = '0;
  bit          p_lsi, p_lse, p_hsi, p_hse;

  function automatic bit rose(bit now, bit was);
    return now && !was;
  endfunction

  task automatic compare();
    n_vec++;
    if (flags !== m_flag) begin
      n_bad++;
      $display("FAIL %s flags actual=%h expected=%h t=%0t", req, flags, m_flag, $time);
    end
    n_vec++;
    if (irq !== (m_flag != 0)) begin
      n_bad++;
      $display("FAIL R9 (%s) irq actual=%b expected=%b", req, irq, m_flag != 0);
    end
  endtask

  // One clock: model consumes the inputs present at the edge
  task automatic tick();
    logic [31:0] set, clr, en_n;
    set = '0; clr = '0; en_n = m_en;
    if (rose(lsi, p_lsi) && m_en[0]) set[0] = 1;
    if (rose(lse, p_lse) && m_en[1]) set[1] = 1;
    if (rose(hsi, p_hsi) && m_en[3] && sw_on) set[3] = 1;
    if (rose(hse, p_hse) && m_en[4]) set[4] = 1;
    if (hfail) set[8] = 1;
    if (lfail) set[9] = 1;
    if (wr_en && wr_addr == 2) clr = wr_data;
    if (wr_en && wr_addr == 0) en_n = {27'd0, wr_data[4:3], 1'b0, wr_data[1:0]};
    @(posedge clk);
    #1;
    for (int b = 0; b < 32; b++)
      if (set[b]) m_flag[b] = 1'b1;
      else if (clr[b]) m_flag[b] = 1'b0;
    m_en = en_n;
    p_lsi = lsi; p_lse = lse; p_hsi = hsi; p_hse = hse;
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    req = "R1"; compare(); idle(2);

    req = "R3"; lsi = 1; idle(2);
    wr(0, 32'h0000_001B); idle(3);

    req = "R2"; lsi = 0; idle(1); lsi = 1; idle(2);
    lse = 1; hse = 1; idle(2);
    sw_on = 1; hsi = 1; idle(2);

    req = "R7"; wr(2, 32'h0000_0001); wr(2, 32'h0); idle(1);
    wr(2, 32'h0000_0012); idle(1);

    req = "R4"; idle(5);

    req = "R5"; hsi = 0; wr(2, 32'h8); idle(1);
    sw_on = 0; hsi = 1; idle(2);
    hsi = 0; idle(1); sw_on = 1; hsi = 1; idle(2);

    req = "R6"; wr(0, 32'h0); hfail = 1; idle(1); hfail = 0; idle(1);
    lfail = 1; idle(2); lfail = 0; wr(2, 32'h0000_0308); idle(1);

    req = "R8"; wr(0, 32'h1B); lse = 0; idle(1);
    lse = 1; wr(2, 32'h2); idle(1);
    hfail = 1; wr(2, 32'h100); hfail = 0; idle(1);

    req = "R10"; wr(1, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF); idle(1);
    wr(0, 32'hFFFF_FFFF); lsi = 0; lse = 0; idle(1); lsi = 1; lse = 1; idle(2);
    wr(2, 32'hFFFF_FFFF); idle(2);

    req = "R2 mix";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 5) == 0) lsi = ~lsi;
      if ($urandom_range(0, 5) == 0) lse = ~lse;
      if ($urandom_range(0, 5) == 0) hsi = ~hsi;
      if ($urandom_range(0, 5) == 0) hse = ~hse;
      sw_on = ($urandom_range(0, 3) != 0);
      hfail = ($urandom_range(0, 15) == 0);
      lfail = ($urandom_range(0, 15) == 0);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = $urandom();
      tick();
    end
    wr_en = 0; hfail = 0; lfail = 0; idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule